// File: doc/BRIEF.md
# Suspend Mode Wake Controller

This block is the power-state sequencer of a USB-attached network interface. While the device is active it stays in a normal state. When a suspend request arrives it moves to one of two suspend states, chosen by a stored two-bit suspend-mode code. The deep state keeps only the minimum alive. The shallow state leaves every clock running.

Each suspend state accepts its own set of wake sources:

- **Deep state:** host resume, or an enabled GPIO pin at its programmed level.
- **Shallow state:** host resume, an enabled GPIO pin, PHY link-up (carried on GPIO bit 7 when selected), or a pulse from the frame filters saying a received frame passed.

On the first qualifying event the controller does three things on the same edge: it issues a one-cycle wake request, records the cause in sticky status bits, and returns to normal. After a wake from the deep state it also flags that the PHY must be re-initialised.

In the shallow state, any enabled wake-on-LAN event makes the receive path discard every frame. In that case frames can no longer wake the device. A frame-caused wake sets the same status bit as an ordinary wake-on-LAN event. Software tells the two apart by reading back the suspend-mode code.

Top module: `suspend_wake_ctrl`

## Requirements
- R1: The suspend-mode code resets to 2'b10 and is loaded from `mode_wdata_i` on a cycle where `mode_wr_i` is high; `susp_mode_o` shows the stored code.
- R2: In normal state (`state_o`=0) a cycle with `susp_req_i` high moves `state_o` on the next edge to 1 (deep) if the code is 2'b10, or to 2 (shallow) if it is 2'b11.
- R3: A suspend request while the code is 2'b00 or 2'b01 leaves `state_o` at 0.
- R4: A GPIO pin wakes only if its bit in `gpio_en_i` is set and its level, after a two-flop synchroniser, equals its bit in `gpio_pol_i`. The wake request appears on the third edge after the pin changes.
- R5: In the deep state, frame-pass pulses and PHY link-up never cause a wake; host resume and enabled GPIO pins do.
- R6: In the shallow state, a `frame_pass_i` pulse wakes on the next edge when `frame_drop_o` is low. Host resume also wakes on the next edge.
- R7: With `link_sel_i` high, bit 7 stands for PHY link-up instead of pin 7. In the shallow state a synchronised high `phy_link_up_i` with `gpio_en_i[7]` set wakes and sets `gpio_sts_o[7]`. With `link_sel_i` high, pin 7 itself is ignored.
- R8: `frame_drop_o` is high exactly when the state is shallow and any bit of `wol_en_i` is set. A frame pulse that arrives while it is high neither wakes nor sets status.
- R9: A wake gives a `wake_req_o` pulse of one cycle. On the same edge `state_o` returns to 0.
- R10: Status bits are sticky. `gpio_sts_o` records the pins that hit, `wol_sts_o` records a frame wake, and `host_sts_o` records a host resume wake. `sts_clr_i` is write-one-to-clear with bits [10:0] for GPIO, 11 for wake-on-LAN, 12 for host and 13 for PHY re-init.
- R11: `phy_reinit_o` is set by every wake out of the deep state and by no wake out of the shallow state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_wr_i | input | 1 | Load strobe for the suspend-mode code |
| mode_wdata_i | input | 2 | New suspend-mode code |
| susp_mode_o | output | 2 | Stored suspend-mode code |
| susp_req_i | input | 1 | Suspend request |
| host_resume_i | input | 1 | Host resume signalling |
| gpio_i | input | 11 | Asynchronous GPIO pins |
| gpio_en_i | input | 11 | Per-pin wake enable |
| gpio_pol_i | input | 11 | Per-pin active level |
| link_sel_i | input | 1 | Bit 7 means PHY link-up |
| phy_link_up_i | input | 1 | Asynchronous PHY link-up level |
| frame_pass_i | input | 1 | Pulse: received frame passed the filters |
| wol_en_i | input | 4 | Wake-on-LAN event enables |
| sts_clr_i | input | 14 | Write-one-to-clear strobes for status |
| state_o | output | 2 | 0 normal, 1 deep, 2 shallow |
| wake_req_o | output | 1 | One-cycle wake request |
| gpio_sts_o | output | 11 | Sticky GPIO/link wake status |
| wol_sts_o | output | 1 | Sticky frame wake status |
| host_sts_o | output | 1 | Sticky host resume wake status |
| phy_reinit_o | output | 1 | Sticky PHY re-initialisation needed |
| frame_drop_o | output | 1 | Receive path drops all frames |

## Verification
Assertions check the following on every cycle:

- State entry for both valid codes, and rejection of the two invalid codes.
- The one-cycle shape of the wake request and the return to normal that comes with it.
- That a frame is ignored while frames are being dropped.
- That the wake-on-LAN status and the re-init flag rise only on exits from the matching state.

The bench scenarios cover what a property cannot:

- The three-edge latency through the synchroniser.
- Per-pin enable and polarity filtering.
- The bit-7 source select.
- The deep state's refusal of frames and link-up.
- The default mode code.
- The write-one-to-clear behaviour of each status bit.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_DEEP    = 2'd1,
    ST_SHALLOW = 2'd2
  } swc_state_e;

  localparam logic [1:0] MODE_DEEP    = 2'b10;
  localparam logic [1:0] MODE_SHALLOW = 2'b11;
  localparam logic [1:0] MODE_RESET   = MODE_DEEP;
endpackage

// File: rtl/swc_wake_sync.sv
module swc_wake_sync #(
  parameter int GPIO_N   = 11,
  parameter int LINK_PIN = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GPIO_N-1:0] gpio_i,
  input  logic [GPIO_N-1:0] gpio_en_i,
  input  logic [GPIO_N-1:0] gpio_pol_i,
  input  logic              link_sel_i,
  input  logic              phy_link_up_i,
  output logic [GPIO_N-1:0] pin_hit_o,
  output logic              link_hit_o
);
  localparam int SYNC_W = GPIO_N + 1;

  logic [SYNC_W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= {phy_link_up_i, gpio_i};
      sync_q <= meta_q;
    end
  end

  for (genvar i = 0; i < GPIO_N; i++) begin : g_pin
    if (i == LINK_PIN) begin : g_shared
      assign pin_hit_o[i] = gpio_en_i[i] && !link_sel_i && (sync_q[i] == gpio_pol_i[i]);
    end else begin : g_plain
      assign pin_hit_o[i] = gpio_en_i[i] && (sync_q[i] == gpio_pol_i[i]);
    end
  end

  assign link_hit_o = link_sel_i && gpio_en_i[LINK_PIN] && sync_q[GPIO_N];
endmodule

// File: rtl/swc_fsm.sv
module swc_fsm
  import swc_pkg::*;
#(
  parameter int GPIO_N   = 11,
  parameter int LINK_PIN = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              susp_req_i,
  input  logic              host_resume_i,
  input  logic [GPIO_N-1:0] pin_hit_i,
  input  logic              link_hit_i,
  input  logic              frame_pass_i,
  input  logic              drop_i,
  output swc_state_e        state_o,
  output logic              wake_req_o,
  output logic [GPIO_N-1:0] set_gpio_o,
  output logic              set_wol_o,
  output logic              set_host_o,
  output logic              set_reinit_o
);
  swc_state_e st_q, st_d;
  logic [GPIO_N-1:0] hit_vec;
  logic frame_ok, wake;

  always_comb begin
    hit_vec = pin_hit_i;
    // link-up counts only when clocks stay on
    if (st_q == ST_SHALLOW) hit_vec[LINK_PIN] = hit_vec[LINK_PIN] | link_hit_i;
    frame_ok = (st_q == ST_SHALLOW) && frame_pass_i && !drop_i;
    wake     = (st_q != ST_NORMAL) && (host_resume_i || (|hit_vec) || frame_ok);
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_NORMAL: begin
        if (susp_req_i && mode_i == MODE_DEEP)         st_d = ST_DEEP;
        else if (susp_req_i && mode_i == MODE_SHALLOW) st_d = ST_SHALLOW;
      end
      ST_DEEP, ST_SHALLOW: if (wake) st_d = ST_NORMAL;
      default: st_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_NORMAL;
      wake_req_o <= 1'b0;
    end else begin
      st_q       <= st_d;
      wake_req_o <= wake;
    end
  end

  assign state_o      = st_q;
  assign set_gpio_o   = wake ? hit_vec : '0;
  assign set_wol_o    = wake && frame_ok;
  assign set_host_o   = wake && host_resume_i;
  assign set_reinit_o = wake && (st_q == ST_DEEP);
endmodule

// File: rtl/swc_status.sv
module swc_status #(
  parameter int STS_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [STS_W-1:0] set_i,
  input  logic [STS_W-1:0] clr_i,
  output logic [STS_W-1:0] sts_o
);
  for (genvar i = 0; i < STS_W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sts_o[i] <= 1'b0;
      else if (set_i[i]) sts_o[i] <= 1'b1;   // set beats clear
      else if (clr_i[i]) sts_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/suspend_wake_ctrl.sv
module suspend_wake_ctrl
  import swc_pkg::*;
#(
  parameter int GPIO_N   = 11,
  parameter int LINK_PIN = 7,
  parameter int WOL_N    = 4,
  localparam int STS_W   = GPIO_N + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_wr_i,
  input  logic [1:0]        mode_wdata_i,
  output logic [1:0]        susp_mode_o,
  input  logic              susp_req_i,
  input  logic              host_resume_i,
  input  logic [GPIO_N-1:0] gpio_i,
  input  logic [GPIO_N-1:0] gpio_en_i,
  input  logic [GPIO_N-1:0] gpio_pol_i,
  input  logic              link_sel_i,
  input  logic              phy_link_up_i,
  input  logic              frame_pass_i,
  input  logic [WOL_N-1:0]  wol_en_i,
  input  logic [STS_W-1:0]  sts_clr_i,
  output logic [1:0]        state_o,
  output logic              wake_req_o,
  output logic [GPIO_N-1:0] gpio_sts_o,
  output logic              wol_sts_o,
  output logic              host_sts_o,
  output logic              phy_reinit_o,
  output logic              frame_drop_o
);
  logic [1:0]        mode_q;
  logic [GPIO_N-1:0] pin_hit, set_gpio;
  logic              link_hit, set_wol, set_host, set_reinit;
  swc_state_e        st;
  logic [STS_W-1:0]  sts;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= MODE_RESET;
    else if (mode_wr_i) mode_q <= mode_wdata_i;
  end

  swc_wake_sync #(.GPIO_N(GPIO_N), .LINK_PIN(LINK_PIN)) u_sync (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .gpio_i        (gpio_i),
    .gpio_en_i     (gpio_en_i),
    .gpio_pol_i    (gpio_pol_i),
    .link_sel_i    (link_sel_i),
    .phy_link_up_i (phy_link_up_i),
    .pin_hit_o     (pin_hit),
    .link_hit_o    (link_hit)
  );

  swc_fsm #(.GPIO_N(GPIO_N), .LINK_PIN(LINK_PIN)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_i        (mode_q),
    .susp_req_i    (susp_req_i),
    .host_resume_i (host_resume_i),
    .pin_hit_i     (pin_hit),
    .link_hit_i    (link_hit),
    .frame_pass_i  (frame_pass_i),
    .drop_i        (frame_drop_o),
    .state_o       (st),
    .wake_req_o    (wake_req_o),
    .set_gpio_o    (set_gpio),
    .set_wol_o     (set_wol),
    .set_host_o    (set_host),
    .set_reinit_o  (set_reinit)
  );

  swc_status #(.STS_W(STS_W)) u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({set_reinit, set_host, set_wol, set_gpio}),
    .clr_i  (sts_clr_i),
    .sts_o  (sts)
  );

  assign frame_drop_o = (st == ST_SHALLOW) && (|wol_en_i);
  assign state_o      = st;
  assign susp_mode_o  = mode_q;
  assign gpio_sts_o   = sts[GPIO_N-1:0];
  assign wol_sts_o    = sts[GPIO_N];
  assign host_sts_o   = sts[GPIO_N+1];
  assign phy_reinit_o = sts[GPIO_N+2];
endmodule

// File: rtl/suspend_wake_ctrl_chk.sv
module suspend_wake_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       susp_req_i,
  input logic [1:0] susp_mode_o,
  input logic [1:0] state_o,
  input logic       wake_req_o,
  input logic       frame_drop_o,
  input logic       frame_pass_i,
  input logic       wol_sts_o,
  input logic       phy_reinit_o
);
  a_r2_enter_deep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && susp_req_i && susp_mode_o == 2'b10) |=> state_o == 2'd1);

  a_r2_enter_shallow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && susp_req_i && susp_mode_o == 2'b11) |=> state_o == 2'd2);

  a_r3_bad_mode_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && !susp_mode_o[1]) |=> state_o == 2'd0);

  a_r9_wake_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |-> (state_o == 2'd0 && $past(state_o) != 2'd0));

  a_r9_wake_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |=> !wake_req_o);

  a_r8_drop_blocks_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_drop_o && frame_pass_i && !wol_sts_o) |=> !wol_sts_o);

  a_r6_wol_from_shallow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wol_sts_o) |-> ($past(state_o) == 2'd2 && $past(frame_pass_i)));

  a_r11_reinit_from_deep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phy_reinit_o) |-> $past(state_o) == 2'd1);
endmodule

bind suspend_wake_ctrl suspend_wake_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .susp_req_i   (susp_req_i),
  .susp_mode_o  (susp_mode_o),
  .state_o      (state_o),
  .wake_req_o   (wake_req_o),
  .frame_drop_o (frame_drop_o),
  .frame_pass_i (frame_pass_i),
  .wol_sts_o    (wol_sts_o),
  .phy_reinit_o (phy_reinit_o)
);

// File: tb/suspend_wake_ctrl_tb.sv
module suspend_wake_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic [1:0]  mode_wdata = 2'b00;
  logic [1:0]  susp_mode;
  logic        susp_req = 1'b0;
  logic        host_resume = 1'b0;
  logic [10:0] gpio = '0;
  logic [10:0] gpio_en = '0;
  logic [10:0] gpio_pol = '1;
  logic        link_sel = 1'b0;
  logic        link_up = 1'b0;
  logic        frame_pass = 1'b0;
  logic [3:0]  wol_en = '0;
  logic [13:0] sts_clr = '0;
  logic [1:0]  state;
  logic        wake_req;
  logic [10:0] gpio_sts;
  logic        wol_sts, host_sts, phy_reinit, frame_drop;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  suspend_wake_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_wr_i(mode_wr), .mode_wdata_i(mode_wdata),
    .susp_mode_o(susp_mode), .susp_req_i(susp_req), .host_resume_i(host_resume),
    .gpio_i(gpio), .gpio_en_i(gpio_en), .gpio_pol_i(gpio_pol), .link_sel_i(link_sel),
    .phy_link_up_i(link_up), .frame_pass_i(frame_pass), .wol_en_i(wol_en),
    .sts_clr_i(sts_clr), .state_o(state), .wake_req_o(wake_req), .gpio_sts_o(gpio_sts),
    .wol_sts_o(wol_sts), .host_sts_o(host_sts), .phy_reinit_o(phy_reinit),
    .frame_drop_o(frame_drop)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic clear_all();
    sts_clr = '1; step(1); sts_clr = '0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_wr = 1'b1; mode_wdata = m; step(1); mode_wr = 1'b0;
  endtask

  task automatic suspend();
    susp_req = 1'b1; step(1); susp_req = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset mode", 32'(susp_mode), 32'h2);
    check("R9 reset state", 32'(state), 32'h0);
    check("R10 reset status", {gpio_sts, wol_sts, host_sts, phy_reinit}, 32'h0);
    check("R8 reset drop", 32'(frame_drop), 32'h0);
  endtask

  task automatic t_bad_mode();
    set_mode(2'b01);
    check("R1 mode write", 32'(susp_mode), 32'h1);
    suspend();
    check("R3 mode 01 ignored", 32'(state), 32'h0);
    set_mode(2'b00);
    suspend();
    check("R3 mode 00 ignored", 32'(state), 32'h0);
  endtask

  task automatic t_deep_gpio();
    set_mode(2'b10);
    gpio_en = 11'h004; gpio_pol = '1;
    suspend();
    check("R2 enter deep", 32'(state), 32'h1);
    check("R8 no drop in deep", 32'(frame_drop), 32'h0);
    gpio[2] = 1'b1;
    step(2);
    check("R4 no wake before sync", 32'(wake_req), 32'h0);
    step(1);
    check("R4 gpio wake", 32'(wake_req), 32'h1);
    check("R9 back to normal", 32'(state), 32'h0);
    check("R10 gpio status", 32'(gpio_sts), 32'h004);
    check("R11 reinit after deep", 32'(phy_reinit), 32'h1);
    step(1);
    check("R9 one-cycle wake", 32'(wake_req), 32'h0);
    gpio = '0; gpio_en = '0; step(3);
    clear_all();
    check("R10 w1c clears", {gpio_sts, wol_sts, host_sts, phy_reinit}, 32'h0);
  endtask

  task automatic t_deep_ignore();
    link_sel = 1'b1; gpio_en = 11'h080;
    suspend();
    link_up = 1'b1;
    frame_pass = 1'b1; step(1); frame_pass = 1'b0;
    step(4);
    check("R5 deep ignores frame/link", 32'(state), 32'h1);
    check("R5 no wol status", 32'(wol_sts), 32'h0);
    host_resume = 1'b1; step(1); host_resume = 1'b0;
    check("R5 host wake from deep", 32'(wake_req), 32'h1);
    check("R10 host status", 32'(host_sts), 32'h1);
    check("R10 gpio untouched", 32'(gpio_sts), 32'h0);
    link_up = 1'b0; link_sel = 1'b0; gpio_en = '0; step(3);
    clear_all();
  endtask

  task automatic t_shallow_frame();
    set_mode(2'b11);
    wol_en = 4'b0100;
    suspend();
    check("R2 enter shallow", 32'(state), 32'h2);
    check("R8 drop with wol enable", 32'(frame_drop), 32'h1);
    frame_pass = 1'b1; step(1); frame_pass = 1'b0;
    check("R8 dropped frame no wake", 32'(state), 32'h2);
    check("R8 dropped frame no status", 32'(wol_sts), 32'h0);
    wol_en = '0; #1;
    check("R8 drop follows enables", 32'(frame_drop), 32'h0);
    step(1);
    frame_pass = 1'b1; step(1); frame_pass = 1'b0;
    check("R6 frame wake", 32'(wake_req), 32'h1);
    check("R10 wol status", 32'(wol_sts), 32'h1);
    check("R11 no reinit from shallow", 32'(phy_reinit), 32'h0);
    check("R8 drop off in normal", 32'(frame_drop), 32'h0);
    sts_clr = 14'h0800; step(1); sts_clr = '0;
    check("R10 w1c wol bit", 32'(wol_sts), 32'h0);
  endtask

  task automatic t_shallow_link();
    link_sel = 1'b1; gpio_en = 11'h080;
    suspend();
    gpio[7] = 1'b1; step(4);
    check("R7 pin 7 ignored when link selected", 32'(state), 32'h2);
    link_up = 1'b1; step(3);
    check("R7 link-up wake", 32'(wake_req), 32'h1);
    check("R7 link status on bit 7", 32'(gpio_sts), 32'h080);
    link_up = 1'b0; link_sel = 1'b0; gpio = '0; gpio_en = '0; step(3);
    clear_all();
  endtask

  task automatic t_polarity();
    gpio_en = 11'h008; gpio_pol = 11'h7F7;
    gpio[3] = 1'b1; gpio[5] = 1'b1; step(3);
    suspend();
    step(4);
    check("R4 wrong level/disabled no wake", 32'(state), 32'h2);
    gpio[3] = 1'b0; step(3);
    check("R4 low-active wake", 32'(wake_req), 32'h1);
    check("R4 only enabled pin status", 32'(gpio_sts), 32'h008);
    gpio = '0; gpio_en = '0; gpio_pol = '1; step(3);
    suspend();
    host_resume = 1'b1; step(1); host_resume = 1'b0;
    check("R6 host wake from shallow", 32'(wake_req), 32'h1);
    check("R10 sticky gpio kept", 32'(gpio_sts), 32'h008);
    clear_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #35 rst_n = 1'b1;
    step(1);
    t_reset();
    t_bad_mode();
    t_deep_gpio();
    t_deep_ignore();
    t_shallow_frame();
    t_shallow_link();
    t_polarity();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule